// File: doc/BRIEF.md
# Ethernet PHY Link Bring-Up Sequencer

This block is a hardware state machine that takes an Ethernet PHY from reset to a usable link. It talks to the PHY's management registers through a simple request port: the sequencer presents a command word that carries a register number and a PHY address, raises a one-cycle request strobe, and then polls a busy flag. The port returns read data once busy drops. The sequencer issues no request until busy is low, and it waits for each access to complete before it starts the next.

A `start` pulse launches the full bring-up. The sequencer resets the PHY and waits for the reset bit to clear. It then polls for link under a bounded poll budget. After link appears it advertises every 10/100 ability, restarts auto-negotiation with a read-modify-write of the control register, and waits for negotiation to complete. It re-checks link and finally reads the partner's abilities, which it resolves into speed and duplex outputs and a link code. A `check` pulse launches a shorter re-check that reads only the status register and, if link is up, the partner abilities. Each sequence ends with a one-cycle `done` pulse.

The state names are `S_IDLE`, `S_RST_WR`, `S_RST_RD`, `S_LINK_RD`, `S_ADV_WR`, `S_CTL_RD`, `S_CTL_WR`, `S_AN_RD`, `S_LINK2_RD`, `S_PART_RD`, `S_CHK_STAT` and `S_CHK_PART`. The transitions are:
- IDLE→RST_WR on start.
- IDLE→CHK_STAT on check when start is low.
- RST_WR→RST_RD.
- RST_RD loops while bit 15 is set, then goes to LINK_RD.
- LINK_RD loops while bit 2 is clear, goes to ADV_WR on link, and goes to IDLE on timeout.
- ADV_WR→CTL_RD→CTL_WR→AN_RD.
- AN_RD loops until bit 5 is set, then goes to LINK2_RD.
- LINK2_RD loops until bit 2 is set, then goes to PART_RD.
- PART_RD→IDLE.
- CHK_STAT→CHK_PART on link, or →IDLE without link.
- CHK_PART→IDLE.

Each access state waits for the access to finish before it takes its transition.

Top module: `phy_linkup_seq`

## Requirements
- R1: After reset the outputs are as follows: `speed_100`=0, `full_duplex`=0, `link_code`=0, `done`=0, and no request is issued.
- R2: A request is signalled by `mgmt_valid` for one cycle, and only while `mgmt_busy` is low. `mgmt_cmd[4:0]` holds the register number and `mgmt_cmd[12:8]` holds `phy_addr`; all other command bits are zero. `mgmt_write` is 1 for writes, and writes carry their data on `mgmt_wdata`. A new request is issued only after `mgmt_busy` has returned low for the previous one.
- R3: Bring-up first writes 0x8000 to register 0. It then reads register 0 repeatedly until bit 15 reads 0.
- R4: Register 1 is then read until bit 2 (link) is 1. If POLL_LIMIT+1 consecutive reads find bit 2 clear, the sequence stops with no further request, with `speed_100`=0, `full_duplex`=0 and `link_code`=0. A read of 1 after exactly POLL_LIMIT failed reads continues the sequence.
- R5: After link, register 4 is written with 0x01E1, which advertises 100 full, 100 half, 10 full and 10 half plus selector bit 0.
- R6: Register 0 is then read, and the value read is written back to register 0 with bit 9 set.
- R7: Register 1 is then read until bit 5 is 1, then read until bit 2 is 1, and then register 5 (partner abilities) is read once.
- R8: Partner bits resolve by priority:
  - bit 8 set: `speed_100`=1, `full_duplex`=1, code 1.
  - otherwise bit 7 set: 1, 0, code 2.
  - otherwise bit 6 set: 0, 1, code 3.
  - otherwise: 0, 0, code 4.
- R9: A re-check reads register 1. If bit 2 is clear, it sets code 0 and leaves speed and duplex unchanged, without reading register 5. Otherwise it reads register 5 and resolves it as in R8.
- R10: `done` is high for exactly one cycle at the end of every sequence. The outputs take their new values in that same cycle and do not change at any other time.
- R11: `start` and `check` are ignored while a sequence runs. When both are high in idle, bring-up is chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Launch full bring-up |
| check | input | 1 | Launch re-check |
| phy_addr | input | 5 | PHY address placed in each command |
| mgmt_valid | output | 1 | One-cycle request strobe |
| mgmt_write | output | 1 | Request is a write |
| mgmt_cmd | output | 16 | Register number [4:0], PHY address [12:8] |
| mgmt_wdata | output | 16 | Write data |
| mgmt_rdata | input | 16 | Read data, valid when busy drops |
| mgmt_busy | input | 1 | Port busy, set from the accepting edge until the access completes |
| speed_100 | output | 1 | 1 = 100 Mb/s, 0 = 10 Mb/s |
| full_duplex | output | 1 | 1 = full duplex |
| link_code | output | 3 | 0 down, 1 100F, 2 100H, 3 10F, 4 10H |
| done | output | 1 | One-cycle end-of-sequence pulse |

## Verification
The bench goes after the following corner cases:
- **Link-wait edge.** It runs the link wait at its exact edge, with POLL_LIMIT failed polls followed by success, and also one failed poll beyond that. An off-by-one counter would either time out a good link or issue one extra poll. Both show up as a request-order mismatch.
- **Priority and re-check.** It sweeps partner words with several bits set and with none set, which catches a reversed priority. A re-check with link down confirms that speed and duplex survive and that register 5 is not read.
- **Stray launches.** Pulses on `start` and `check` during a running sequence would, if honoured, restart it and show up as unexpected requests.
- **Restart write.** The read-modify-write is checked against a varied control value, so a design that writes a constant instead of the value it read fails the comparison.

// File: rtl/phy_seq_pkg.sv
package phy_seq_pkg;

    localparam int REG_W    = 5;
    localparam int ADDR_W   = 5;
    localparam int ADDR_POS = 8;
    localparam int CMD_W    = ADDR_POS + ADDR_W + 3;

    localparam logic [REG_W-1:0] RG_CTRL   = 5'd0;
    localparam logic [REG_W-1:0] RG_STAT   = 5'd1;
    localparam logic [REG_W-1:0] RG_ADV    = 5'd4;
    localparam logic [REG_W-1:0] RG_PART   = 5'd5;

    localparam int BIT_RESET   = 15;
    localparam int BIT_RESTART = 9;
    localparam int BIT_LINK    = 2;
    localparam int BIT_ANDONE  = 5;

    localparam logic [15:0] ADV_WORD = 16'h01E1;

    localparam logic [2:0] LC_DOWN = 3'd0;
    localparam logic [2:0] LC_100F = 3'd1;
    localparam logic [2:0] LC_100H = 3'd2;
    localparam logic [2:0] LC_10F  = 3'd3;
    localparam logic [2:0] LC_10H  = 3'd4;

    typedef enum logic [3:0] {
        S_IDLE, S_RST_WR, S_RST_RD, S_LINK_RD, S_ADV_WR, S_CTL_RD,
        S_CTL_WR, S_AN_RD, S_LINK2_RD, S_PART_RD, S_CHK_STAT, S_CHK_PART
    } seq_state_t;

    typedef enum logic [1:0] {
        E_IDLE, E_ISSUE, E_WAIT
    } eng_state_t;

endpackage

// File: rtl/mgmt_access.sv
module mgmt_access
    import phy_seq_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              wr,
    input  logic [REG_W-1:0]  regnum,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] phy_addr,
    output logic              fin,
    output logic [DATA_W-1:0] rdata,
    output logic              mgmt_valid,
    output logic              mgmt_write,
    output logic [CMD_W-1:0]  mgmt_cmd,
    output logic [DATA_W-1:0] mgmt_wdata,
    input  logic [DATA_W-1:0] mgmt_rdata,
    input  logic              mgmt_busy
);

    eng_state_t        eng_q;
    logic              wr_q;
    logic [REG_W-1:0]  reg_q;
    logic [DATA_W-1:0] wd_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eng_q <= E_IDLE;
            wr_q  <= 1'b0;
            reg_q <= '0;
            wd_q  <= '0;
        end else begin
            unique case (eng_q)
                E_IDLE: begin
                    if (go) begin
                        wr_q  <= wr;
                        reg_q <= regnum;
                        wd_q  <= wdata;
                        eng_q <= E_ISSUE;
                    end
                end
                E_ISSUE: if (!mgmt_busy) eng_q <= E_WAIT;
                E_WAIT:  if (!mgmt_busy) eng_q <= E_IDLE;
                default: eng_q <= E_IDLE;
            endcase
        end
    end

    always_comb begin
        mgmt_cmd                       = '0;
        mgmt_cmd[REG_W-1:0]            = reg_q;
        mgmt_cmd[ADDR_POS +: ADDR_W]   = phy_addr;
        mgmt_valid = (eng_q == E_ISSUE) && !mgmt_busy;
        fin        = (eng_q == E_WAIT) && !mgmt_busy;
        mgmt_write = wr_q;
        mgmt_wdata = wd_q;
        rdata      = mgmt_rdata;
    end

endmodule

// File: rtl/poll_limit_ctr.sv
module poll_limit_ctr #(
    parameter int LIMIT = 10000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic at_limit
);

    localparam int CW = $clog2(LIMIT + 1) + 1;

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt_q <= '0;
        else if (clr)     cnt_q <= '0;
        else if (inc)     cnt_q <= cnt_q + 1'b1;
    end

    assign at_limit = (cnt_q == CW'(LIMIT));

endmodule

// File: rtl/ability_resolve.sv
module ability_resolve
    import phy_seq_pkg::*;
(
    input  logic [3:0] caps,
    output logic       spd,
    output logic       dup,
    output logic [2:0] code
);

    always_comb begin
        if (caps[3]) begin
            spd = 1'b1; dup = 1'b1; code = LC_100F;
        end else if (caps[2]) begin
            spd = 1'b1; dup = 1'b0; code = LC_100H;
        end else if (caps[1]) begin
            spd = 1'b0; dup = 1'b1; code = LC_10F;
        end else begin
            spd = 1'b0; dup = 1'b0; code = LC_10H;
        end
    end

endmodule

// File: rtl/phy_linkup_seq.sv
module phy_linkup_seq
    import phy_seq_pkg::*;
#(
    parameter int POLL_LIMIT = 10000,
    parameter int DATA_W     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              check,
    input  logic [4:0]        phy_addr,
    output logic              mgmt_valid,
    output logic              mgmt_write,
    output logic [15:0]       mgmt_cmd,
    output logic [DATA_W-1:0] mgmt_wdata,
    input  logic [DATA_W-1:0] mgmt_rdata,
    input  logic              mgmt_busy,
    output logic              speed_100,
    output logic              full_duplex,
    output logic [2:0]        link_code,
    output logic              done
);

    seq_state_t        state_q, state_d;
    logic              pend_q;
    logic [DATA_W-1:0] ctl_q;

    logic              acc_go, acc_wr, acc_fin;
    logic [REG_W-1:0]  acc_reg;
    logic [DATA_W-1:0] acc_wdata, acc_rdata;
    logic              at_limit, link_bit, an_bit, rst_bit;
    logic              res_spd, res_dup;
    logic [2:0]        res_code;
    logic              is_access;

    assign link_bit = acc_rdata[BIT_LINK];
    assign an_bit   = acc_rdata[BIT_ANDONE];
    assign rst_bit  = acc_rdata[BIT_RESET];

    mgmt_access #(.DATA_W(DATA_W)) u_acc (
        .clk        (clk),
        .rst_n      (rst_n),
        .go         (acc_go),
        .wr         (acc_wr),
        .regnum     (acc_reg),
        .wdata      (acc_wdata),
        .phy_addr   (phy_addr),
        .fin        (acc_fin),
        .rdata      (acc_rdata),
        .mgmt_valid (mgmt_valid),
        .mgmt_write (mgmt_write),
        .mgmt_cmd   (mgmt_cmd),
        .mgmt_wdata (mgmt_wdata),
        .mgmt_rdata (mgmt_rdata),
        .mgmt_busy  (mgmt_busy)
    );

    poll_limit_ctr #(.LIMIT(POLL_LIMIT)) u_poll (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (state_q != S_LINK_RD),
        .inc      ((state_q == S_LINK_RD) && acc_fin && !link_bit),
        .at_limit (at_limit)
    );

    ability_resolve u_res (
        .caps (acc_rdata[8:5]),
        .spd  (res_spd),
        .dup  (res_dup),
        .code (res_code)
    );

    // Access descriptor for the current state
    always_comb begin
        acc_wr    = 1'b0;
        acc_reg   = RG_STAT;
        acc_wdata = '0;
        is_access = 1'b1;
        unique case (state_q)
            S_IDLE:     is_access = 1'b0;
            S_RST_WR: begin
                acc_wr = 1'b1; acc_reg = RG_CTRL;
                acc_wdata = '0; acc_wdata[BIT_RESET] = 1'b1;
            end
            S_RST_RD, S_CTL_RD: acc_reg = RG_CTRL;
            S_LINK_RD, S_AN_RD, S_LINK2_RD, S_CHK_STAT: acc_reg = RG_STAT;
            S_ADV_WR: begin
                acc_wr = 1'b1; acc_reg = RG_ADV; acc_wdata = DATA_W'(ADV_WORD);
            end
            S_CTL_WR: begin
                acc_wr = 1'b1; acc_reg = RG_CTRL;
                acc_wdata = ctl_q; acc_wdata[BIT_RESTART] = 1'b1;
            end
            S_PART_RD, S_CHK_PART: acc_reg = RG_PART;
            default:    is_access = 1'b0;
        endcase
        acc_go = is_access && !pend_q;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: begin
                if (start)      state_d = S_RST_WR;
                else if (check) state_d = S_CHK_STAT;
            end
            S_RST_WR:   if (acc_fin) state_d = S_RST_RD;
            S_RST_RD:   if (acc_fin && !rst_bit) state_d = S_LINK_RD;
            S_LINK_RD: begin
                if (acc_fin) begin
                    if (link_bit)      state_d = S_ADV_WR;
                    else if (at_limit) state_d = S_IDLE;
                end
            end
            S_ADV_WR:   if (acc_fin) state_d = S_CTL_RD;
            S_CTL_RD:   if (acc_fin) state_d = S_CTL_WR;
            S_CTL_WR:   if (acc_fin) state_d = S_AN_RD;
            S_AN_RD:    if (acc_fin && an_bit) state_d = S_LINK2_RD;
            S_LINK2_RD: if (acc_fin && link_bit) state_d = S_PART_RD;
            S_PART_RD:  if (acc_fin) state_d = S_IDLE;
            S_CHK_STAT: if (acc_fin) state_d = link_bit ? S_CHK_PART : S_IDLE;
            S_CHK_PART: if (acc_fin) state_d = S_IDLE;
            default:    state_d = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // Access bookkeeping: one outstanding access per state visit
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q <= 1'b0;
            ctl_q  <= '0;
        end else begin
            if (acc_fin)     pend_q <= 1'b0;
            else if (acc_go) pend_q <= 1'b1;
            if (state_q == S_CTL_RD && acc_fin) ctl_q <= acc_rdata;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            speed_100   <= 1'b0;
            full_duplex <= 1'b0;
            link_code   <= LC_DOWN;
            done        <= 1'b0;
        end else begin
            done <= 1'b0;
            if (acc_fin) begin
                if (state_q == S_LINK_RD && !link_bit && at_limit) begin
                    speed_100   <= 1'b0;
                    full_duplex <= 1'b0;
                    link_code   <= LC_DOWN;
                    done        <= 1'b1;
                end
                if (state_q == S_PART_RD || state_q == S_CHK_PART) begin
                    speed_100   <= res_spd;
                    full_duplex <= res_dup;
                    link_code   <= res_code;
                    done        <= 1'b1;
                end
                if (state_q == S_CHK_STAT && !link_bit) begin
                    link_code   <= LC_DOWN;
                    done        <= 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/phy_linkup_seq_chk.sv
module phy_linkup_seq_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        mgmt_valid,
    input logic        mgmt_busy,
    input logic [15:0] mgmt_cmd,
    input logic [4:0]  phy_addr,
    input logic        speed_100,
    input logic        full_duplex,
    input logic [2:0]  link_code,
    input logic        done
);

    assert_issue_free_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_valid |-> !mgmt_busy);

    assert_issue_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_valid |=> !mgmt_valid);

    assert_cmd_fields_R2: assert property (@(posedge clk) disable iff (!rst_n)
        mgmt_valid |-> (mgmt_cmd[12:8] == phy_addr && mgmt_cmd[15:13] == 3'd0
                        && mgmt_cmd[7:5] == 3'd0));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_out_only_on_done_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({speed_100, full_duplex, link_code}) |-> done);

    assert_code_range_R8: assert property (@(posedge clk) disable iff (!rst_n)
        link_code <= 3'd4);

    assert_code_mode_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (link_code != 3'd0) |-> (
            (link_code == 3'd1 && speed_100 && full_duplex) ||
            (link_code == 3'd2 && speed_100 && !full_duplex) ||
            (link_code == 3'd3 && !speed_100 && full_duplex) ||
            (link_code == 3'd4 && !speed_100 && !full_duplex)));

endmodule

bind phy_linkup_seq phy_linkup_seq_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mgmt_valid  (mgmt_valid),
    .mgmt_busy   (mgmt_busy),
    .mgmt_cmd    (mgmt_cmd),
    .phy_addr    (phy_addr),
    .speed_100   (speed_100),
    .full_duplex (full_duplex),
    .link_code   (link_code),
    .done        (done)
);

// File: tb/tb_phy_linkup_seq.sv
`timescale 1ns/1ps
module tb_phy_linkup_seq;

    localparam int TB_POLL = 6;
    localparam int LAT     = 2;
    localparam logic [4:0] TB_ADDR = 5'h13;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0, check = 1'b0;
    logic        mgmt_valid, mgmt_write, mgmt_busy;
    logic [15:0] mgmt_cmd, mgmt_wdata, mgmt_rdata;
    logic        speed_100, full_duplex, done;
    logic [2:0]  link_code;

    always #2 clk = ~clk;

    phy_linkup_seq #(.POLL_LIMIT(TB_POLL), .DATA_W(16)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .check(check),
        .phy_addr(TB_ADDR), .mgmt_valid(mgmt_valid), .mgmt_write(mgmt_write),
        .mgmt_cmd(mgmt_cmd), .mgmt_wdata(mgmt_wdata), .mgmt_rdata(mgmt_rdata),
        .mgmt_busy(mgmt_busy), .speed_100(speed_100), .full_duplex(full_duplex),
        .link_code(link_code), .done(done)
    );

    int compared = 0, mismatched = 0;

    // PHY register model behind the request/busy port
    int          rst_delay = 0, link_delay = 0, an_delay = 0;
    int          stat_reads = 0, rst_cnt = 0;
    logic [15:0] ctl_base = 16'h0, partner = 16'h0;
    bit          link_force_down = 0;
    int          lat_cnt = 0;
    logic        busy_r = 1'b0;
    logic [15:0] rdata_r = 16'h0;
    assign mgmt_busy  = busy_r;
    assign mgmt_rdata = rdata_r;

    always @(posedge clk) begin
        if (!rst_n) begin
            busy_r <= 1'b0; lat_cnt <= 0; rdata_r <= 16'h0;
        end else if (mgmt_valid) begin
            logic [15:0] v;
            v = 16'h0;
            busy_r  <= 1'b1;
            lat_cnt <= LAT;
            case (mgmt_cmd[4:0])
                5'd0: if (mgmt_write) begin
                          if (mgmt_wdata[15]) rst_cnt = rst_delay;
                      end else begin
                          v = ctl_base;
                          if (rst_cnt > 0) begin v[15] = 1'b1; rst_cnt--; end
                      end
                5'd1: if (!mgmt_write) begin
                          if (!link_force_down && stat_reads >= link_delay) v[2] = 1'b1;
                          if (stat_reads >= an_delay) v[5] = 1'b1;
                          stat_reads++;
                      end
                5'd5: v = partner;
                default: v = 16'h0;
            endcase
            rdata_r <= v;
        end else if (busy_r) begin
            if (lat_cnt == 0) busy_r <= 1'b0;
            else              lat_cnt <= lat_cnt - 1;
        end
    end

    // Scoreboard of expected requests
    typedef struct packed {
        logic        wr;
        logic [4:0]  rg;
        logic [15:0] wd;
        logic [3:0]  tag;
    } req_t;
    req_t exp_q[$];

    task automatic push(bit wr, bit [4:0] rg, bit [15:0] wd, int tag);
        req_t it;
        it.wr = wr; it.rg = rg; it.wd = wd; it.tag = tag[3:0];
        exp_q.push_back(it);
    endtask

    // Monitor: R2 request format and order
    always @(negedge clk) begin
        if (rst_n && mgmt_valid) begin
            logic [15:0] ecmd;
            req_t e;
            compared++;
            if (exp_q.size() == 0) begin
                mismatched++;
                $display("FAIL R2 unexpected request cmd=%h wr=%0d (expected none)",
                         mgmt_cmd, mgmt_write);
            end else begin
                e = exp_q.pop_front();
                ecmd = {3'b000, TB_ADDR, 3'b000, e.rg};
                if (mgmt_cmd !== ecmd || mgmt_write !== e.wr ||
                    (e.wr && mgmt_wdata !== e.wd) || mgmt_busy !== 1'b0) begin
                    mismatched++;
                    $display("FAIL R%0d request cmd=%h wr=%0d wd=%h expected cmd=%h wr=%0d wd=%h",
                             e.tag, mgmt_cmd, mgmt_write, mgmt_wdata, ecmd, e.wr, e.wd);
                end
            end
        end
    end

    task automatic chk(bit ok, string req, string what, int act, int expv);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic wait_done();
        int n = 0;
        while (done !== 1'b1 && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic check_end(string req, logic esp, logic edp, logic [2:0] ecode);
        wait_done();
        chk(done === 1'b1, "R10", "done seen", done, 1);
        chk(speed_100 === esp && full_duplex === edp && link_code === ecode, req,
            "{speed,duplex,code}", {speed_100, full_duplex, link_code}, {esp, edp, ecode});
        chk(exp_q.size() == 0, req, "requests left over", exp_q.size(), 0);
        @(negedge clk);
        chk(done === 1'b0, "R10", "done one cycle", done, 0);
    endtask

    task automatic run_bringup(int rd, int ld, int ad, logic [15:0] ctl, logic [15:0] part,
                               bit timeout, bit poke, bit both,
                               logic esp, logic edp, logic [2:0] ecode, string req);
        int an_n;
        rst_delay = rd; link_delay = ld; an_delay = ad; ctl_base = ctl;
        partner = part; link_force_down = 0; stat_reads = 0; rst_cnt = 0;
        push(1, 5'd0, 16'h8000, 3);                                // R3 reset write
        for (int i = 0; i < rd + 1; i++) push(0, 5'd0, 16'h0, 3);  // R3 reset polls
        if (timeout) begin
            for (int i = 0; i < TB_POLL + 1; i++) push(0, 5'd1, 16'h0, 4); // R4
        end else begin
            for (int i = 0; i < ld + 1; i++) push(0, 5'd1, 16'h0, 4);      // R4
            push(1, 5'd4, 16'h01E1, 5);                                    // R5
            push(0, 5'd0, 16'h0, 6);                                       // R6
            push(1, 5'd0, ctl | 16'h0200, 6);                              // R6
            an_n = (ad > ld + 1) ? ad - ld : 1;
            for (int i = 0; i < an_n; i++) push(0, 5'd1, 16'h0, 7);        // R7
            push(0, 5'd1, 16'h0, 7);
            push(0, 5'd5, 16'h0, 7);
        end
        start = 1'b1; check = both;
        @(negedge clk);
        start = 1'b0; check = 1'b0;
        if (poke) begin   // R11: launches while running are ignored
            repeat (12) @(negedge clk);
            start = 1'b1; check = 1'b1;
            @(negedge clk);
            start = 1'b0; check = 1'b0;
        end
        check_end(req, esp, edp, ecode);
    endtask

    task automatic run_check(bit up, logic [15:0] part,
                             logic esp, logic edp, logic [2:0] ecode);
        link_force_down = !up; link_delay = 0; an_delay = 0;
        stat_reads = 0; partner = part;
        push(0, 5'd1, 16'h0, 9);                  // R9 status read
        if (up) push(0, 5'd5, 16'h0, 9);          // R9 partner read
        check = 1'b1;
        @(negedge clk);
        check = 1'b0;
        check_end(up ? "R8" : "R9", esp, edp, ecode);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        mismatched++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(speed_100 === 1'b0 && full_duplex === 1'b0 && link_code === 3'd0 &&
            done === 1'b0 && mgmt_valid === 1'b0, "R1", "reset outputs",
            {speed_100, full_duplex, link_code, done, mgmt_valid}, 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk(mgmt_valid === 1'b0 && done === 1'b0, "R1", "idle after reset",
            {mgmt_valid, done}, 0);

        // Full bring-up, 100 full, with stray launches mid-run (R3 R5 R6 R7 R8 R11)
        run_bringup(2, 3, 7, 16'h3100, 16'h01E1, 0, 1, 0, 1'b1, 1'b1, 3'd1, "R8");

        // Link timeout (R4): forced 10 half, code down, no further requests
        run_bringup(0, 1000, 0, 16'h1000, 16'h01E1, 1, 0, 0, 1'b0, 1'b0, 3'd0, "R4");
        repeat (30) @(negedge clk);
        chk(exp_q.size() == 0 && link_code === 3'd0, "R4", "quiet after timeout",
            link_code, 0);

        // Exactly POLL_LIMIT failed polls then link (R4 boundary), partner 100 half
        run_bringup(1, TB_POLL, 0, 16'h1000, 16'h0081, 0, 0, 0, 1'b1, 1'b0, 3'd2, "R4");

        // Re-checks across the priority ladder (R8, R9)
        run_check(1, 16'h0060, 1'b0, 1'b1, 3'd3);
        run_check(1, 16'h0020, 1'b0, 1'b0, 3'd4);
        run_check(1, 16'h0000, 1'b0, 1'b0, 3'd4);
        run_check(1, 16'h00C0, 1'b1, 1'b0, 3'd2);
        run_check(1, 16'h0100, 1'b1, 1'b1, 3'd1);
        // Link down: code 0, speed and duplex kept (R9)
        run_check(0, 16'h01E0, 1'b1, 1'b1, 3'd0);

        // start and check together in idle: bring-up wins (R11)
        run_bringup(0, 0, 3, 16'h2100, 16'h0040, 0, 0, 1, 1'b0, 1'b1, 3'd3, "R11");

        repeat (5) @(negedge clk);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule